// File: doc/BRIEF.md
# Serial Temperature Sensor Reader

This block reads a temperature sensor that streams its result over a three-wire serial link. The block is the link master. It drives the active-low select and the serial clock, and it shifts in one data bit on every falling clock edge. The line that carries commands to the sensor is held low, so the block never sends a command.

A frame opens with a fresh falling edge on select and carries sixteen clock periods. Its first ten bits are a two's-complement temperature, sent MSB first. The block drops the remaining bits.

The assembled reading moves to a holding register at the same clock edge that raises select again. A one-cycle valid pulse marks that transfer. The host can request one frame with a start pulse, or hold free-run high to read back to back. Select stays high for a programmable minimum time between frames. The serial clock rate comes from a divider parameter.

Top module: `tsense_reader`

## Requirements
- R1: While `rst_ni` is low, `cs_no` is 1, `sclk_o` is 0, `temp_o` is 0, and `valid_o` and `busy_o` are 0.
- R2: A frame begins only from idle. It begins when `start_i` or `free_run_i` is high at a clock edge after `cs_no` has been high for at least CS_GAP+1 cycles. `cs_no` then stays low for exactly (2*FRAME_BITS+1)*HALF_DIV cycles.
- R3: The cycles of a frame are counted from 0, starting with the cycle after `cs_no` falls. `sclk_o` is high when t >= HALF_DIV, t < (2*FRAME_BITS+1)*HALF_DIV - HALF_DIV, and ((t-HALF_DIV)/HALF_DIV) is even. At all other times it is low.
- R4: `sens_data_i` is captured at each falling edge of `sclk_o`. The first bit captured is the most significant bit of the frame.
- R5: At the end of a frame, `temp_o` takes the first TEMP_BITS bits of the frame, MSB first. The remaining FRAME_BITS-TEMP_BITS bits do not affect it.
- R6: `valid_o` is high for exactly one cycle, in the cycle in which `cs_no` returns high and `temp_o` takes its new value.
- R7: `busy_o` is high exactly while `cs_no` is low.
- R8: `start_i` has no effect while a frame is in progress. The frame keeps its length and no second frame is queued.
- R9: With `start_i` and `free_run_i` both low, `cs_no` stays high and no frame takes place.
- R10: `sens_cmd_o` is 0 at all times.
- R11: `temp_o` changes only in a cycle in which `valid_o` is high. Activity on `sens_data_i` outside a frame leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one frame (ignored while busy) |
| free_run_i | input | 1 | Run frames back to back while high |
| sens_data_i | input | 1 | Serial data from the sensor |
| sclk_o | output | 1 | Serial clock to the sensor, idle low |
| cs_no | output | 1 | Active-low sensor select |
| sens_cmd_o | output | 1 | Command line to the sensor, held low |
| temp_o | output | TEMP_BITS | Last complete two's-complement reading |
| valid_o | output | 1 | One-cycle pulse when temp_o is updated |
| busy_o | output | 1 | High while a frame is in progress |

## Verification
The bench puts several kinds of words on the data line: all ones, all zeros, a lone sign bit, and mixed patterns whose low six bits disagree with the top ten. A design that captured on the wrong clock edge, or took the wrong slice of the frame, would show a shifted or contaminated reading. A start pulse arrives in the middle of a frame. A design that restarted there, or queued a second frame, would show the wrong select length or an extra valid pulse. Free-run mode checks that the gap between frames is exactly CS_GAP+1 cycles. Long idle stretches with a toggling data line check that no frame starts without a request and that the holding register does not change.

// File: rtl/tsense_pkg.sv
package tsense_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_DONE
  } tsense_state_e;
endpackage

// File: rtl/tsense_tick.sv
module tsense_tick #(
  parameter int unsigned HALF_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/tsense_shift.sv
module tsense_shift #(
  parameter int unsigned FRAME_BITS = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  en_i,
  input  logic                  bit_i,
  output logic [FRAME_BITS-1:0] word_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    word_o <= '0;
    else if (clr_i) word_o <= '0;
    else if (en_i)  word_o <= {word_o[FRAME_BITS-2:0], bit_i};
  end
endmodule

// File: rtl/tsense_fsm.sv
module tsense_fsm
  import tsense_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 16,
  parameter int unsigned CS_GAP     = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  input  logic tick_i,
  output logic run_o,
  output logic sclk_o,
  output logic cs_no,
  output logic busy_o,
  output logic sample_o,
  output logic load_o
);
  localparam int unsigned BW = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
  localparam int unsigned GW = $clog2(CS_GAP + 2);
  localparam logic [BW-1:0] BIT_LAST = BW'(FRAME_BITS - 1);
  localparam logic [GW-1:0] GAP_END  = GW'(CS_GAP);

  tsense_state_e state_q;
  logic [BW-1:0] bit_q;
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      gap_q   <= '0;
      sclk_o  <= 1'b0;
      cs_no   <= 1'b1;
      busy_o  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (gap_q != GAP_END) gap_q <= gap_q + 1'b1;
          if (go_i && gap_q == GAP_END) begin
            state_q <= ST_SETUP;
            cs_no   <= 1'b0;
            busy_o  <= 1'b1;
            bit_q   <= '0;
          end
        end
        ST_SETUP: if (tick_i) begin
          state_q <= ST_HIGH;
          sclk_o  <= 1'b1;
        end
        ST_HIGH: if (tick_i) begin
          sclk_o <= 1'b0;
          if (bit_q == BIT_LAST) state_q <= ST_DONE;
          else begin
            state_q <= ST_LOW;
            bit_q   <= bit_q + 1'b1;
          end
        end
        ST_LOW: if (tick_i) begin
          state_q <= ST_HIGH;
          sclk_o  <= 1'b1;
        end
        ST_DONE: if (tick_i) begin
          state_q <= ST_IDLE;
          cs_no   <= 1'b1;
          busy_o  <= 1'b0;
          gap_q   <= '0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign run_o    = (state_q != ST_IDLE);
  assign sample_o = (state_q == ST_HIGH) && tick_i;
  assign load_o   = (state_q == ST_DONE) && tick_i;

  // select may fall only after the full idle gap
  assert_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> $past(gap_q) == GAP_END);
  assert_sclk_in_frame_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !cs_no);
  assert_sample_on_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> $fell(sclk_o));
  assert_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o == !cs_no);
endmodule

// File: rtl/tsense_reader.sv
module tsense_reader #(
  parameter int unsigned HALF_DIV   = 4,
  parameter int unsigned FRAME_BITS = 16,
  parameter int unsigned TEMP_BITS  = 10,
  parameter int unsigned CS_GAP     = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 free_run_i,
  input  logic                 sens_data_i,
  output logic                 sclk_o,
  output logic                 cs_no,
  output logic                 sens_cmd_o,
  output logic [TEMP_BITS-1:0] temp_o,
  output logic                 valid_o,
  output logic                 busy_o
);
  logic run, tick, sample, load;
  logic [FRAME_BITS-1:0] word;

  tsense_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .tick_o(tick)
  );

  tsense_fsm #(.FRAME_BITS(FRAME_BITS), .CS_GAP(CS_GAP)) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (start_i | free_run_i),
    .tick_i  (tick),
    .run_o   (run),
    .sclk_o  (sclk_o),
    .cs_no   (cs_no),
    .busy_o  (busy_o),
    .sample_o(sample),
    .load_o  (load)
  );

  tsense_shift #(.FRAME_BITS(FRAME_BITS)) u_shift (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (!run),
    .en_i  (sample),
    .bit_i (sens_data_i),
    .word_o(word)
  );

  // holding register, written only as select returns high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      temp_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= load;
      if (load) temp_o <= word[FRAME_BITS-1 -: TEMP_BITS];
    end
  end

  assign sens_cmd_o = 1'b0;

  assert_valid_on_cs_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> cs_no && !$past(cs_no));
  assert_valid_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  assert_temp_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(temp_o));
endmodule

// File: tb/tsense_reader_tb_top.sv
module tsense_reader_tb_top;
  localparam int D = 2;
  localparam int F = 16;
  localparam int T = 10;
  localparam int GAP = 3;
  localparam int L = (2 * F + 1) * D;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start = 1'b0, free_run = 1'b0, sdi = 1'b0;
  logic sclk, cs_n, cmd, valid, busy;
  logic [T-1:0] temp;

  always #4 clk = ~clk;

  tsense_reader #(.HALF_DIV(D), .FRAME_BITS(F), .TEMP_BITS(T), .CS_GAP(GAP)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .free_run_i(free_run),
    .sens_data_i(sdi), .sclk_o(sclk), .cs_no(cs_n), .sens_cmd_o(cmd),
    .temp_o(temp), .valid_o(valid), .busy_o(busy)
  );

  int total = 0, bad = 0, cyc = 0;
  int n_valid = 0, n_cs_low = 0, gap_run = 0, last_gap = -1;
  logic [F-1:0] words[$];
  logic [F-1:0] cur_word;
  logic m_active = 1'b0, m_sclk = 1'b0, m_cs_n = 1'b1, m_busy = 1'b0, m_valid = 1'b0;
  logic [T-1:0] m_temp = '0;
  int m_t = 0, m_gap = 0;
  logic noise = 1'b0;

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s cycle %0d actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(cs_n == m_cs_n, "R2 cs_no", cs_n, m_cs_n);
    chk(sclk == m_sclk, "R3 sclk_o", sclk, m_sclk);
    chk(temp == m_temp, "R5 temp_o", temp, m_temp);
    chk(valid == m_valid, "R6 valid_o", valid, m_valid);
    chk(busy == m_busy, "R7 busy_o", busy, m_busy);
    chk(cmd == 1'b0, "R10 sens_cmd_o", cmd, 0);
  endtask

  task automatic tick();
    logic prev;
    @(posedge clk);
    m_valid = 1'b0;
    if (m_active) begin
      prev = m_sclk;
      m_t++;
      if (m_t == L) begin
        m_active = 1'b0; m_cs_n = 1'b1; m_sclk = 1'b0; m_busy = 1'b0;
        m_valid = 1'b1; m_temp = cur_word[F-1 -: T]; m_gap = 0;
      end else begin
        m_sclk = (m_t >= D) && (m_t < L - D) && (((m_t - D) / D) % 2 == 0);
      end
    end else if ((start || free_run) && m_gap == GAP) begin
      m_active = 1'b1; m_t = 0; m_cs_n = 1'b0; m_busy = 1'b1;
      cur_word = (words.size() > 0) ? words.pop_front() : '0;
    end else if (m_gap < GAP) begin
      m_gap++;
    end
    @(negedge clk);
    cyc++;
    compare_all();
    if (valid) n_valid++;
    if (!cs_n) begin
      n_cs_low++;
      if (gap_run > 0) last_gap = gap_run;
      gap_run = 0;
    end else gap_run++;
    // sensor model: a bit appears on the rising clock edge and holds until the next
    if (m_active && m_t >= D) begin
      int b;
      b = (m_t - D) / (2 * D);
      sdi = (b < F) ? cur_word[F-1-b] : 1'b0;
    end else if (!m_active) begin
      noise = ~noise;
      sdi = noise;
    end
  endtask

  task automatic run_cycles(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic one_frame(input logic [F-1:0] w);
    int v0;
    v0 = n_valid;
    words.push_back(w);
    start = 1'b1;
    tick();
    start = 1'b0;
    run_cycles(L + GAP + 4);
    chk(n_valid == v0 + 1, "R6 one valid per frame", n_valid - v0, 1);
    chk(temp == w[F-1 -: T], "R4 R5 reading", temp, w[F-1 -: T]);
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v0, c0;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk(cs_n == 1'b1 && sclk == 1'b0 && busy == 1'b0, "R1 ctrl idle", {cs_n, sclk, busy}, 3'b100);
    chk(temp == '0 && valid == 1'b0, "R1 temp clear", temp, 0);
    rst_ni = 1'b1;

    // R9: no request, no frame, data line toggling
    run_cycles(40);
    chk(n_cs_low == 0, "R9 idle without request", n_cs_low, 0);

    one_frame(16'hA5C3);
    one_frame(16'h0000);
    one_frame(16'hFFFF);
    one_frame(16'h803F);   // sign bit only in top field, low bits set (R5)
    one_frame(16'h7FC0);

    // R8: start pulse mid-frame is ignored
    v0 = n_valid; c0 = n_cs_low;
    words.push_back(16'h5A5A);
    start = 1'b1; tick(); start = 1'b0;
    run_cycles(20);
    start = 1'b1; tick(); start = 1'b0;
    run_cycles(L + GAP + 10);
    chk(n_valid == v0 + 1, "R8 no queued frame", n_valid - v0, 1);
    chk(n_cs_low - c0 == L, "R8 frame length kept", n_cs_low - c0, L);

    // R11: hold with data noise, no request
    run_cycles(50);
    chk(temp == 10'(16'h5A5A >> (F - T)), "R11 temp held", temp, 16'h5A5A >> (F - T));

    // R2: free-run back to back, gap of GAP+1
    words.push_back(16'h1234);
    words.push_back(16'hFE00);
    words.push_back(16'hC0FF);
    v0 = n_valid;
    free_run = 1'b1;
    run_cycles(3 * (L + GAP + 1) - 2);
    free_run = 1'b0;
    run_cycles(L + GAP + 4);
    chk(n_valid - v0 >= 3, "R2 free-run frames", n_valid - v0, 3);
    chk(last_gap == GAP + 1, "R2 minimum select gap", last_gap, GAP + 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule